// File: doc/BRIEF.md
# Two-wire register target with word-sized auto-increment

This block is the target side of an I2C link. It gives an external master access to an internal register and memory space through a 16-bit subaddress. SCL and SDA are brought into the fast system clock through a synchroniser. The block then detects start, repeated start and stop conditions, compares the 7-bit chip address, and carries out single or burst transfers in either direction. Towards the inside of the chip it presents a plain register bus: an address, a write word with a write strobe, and a read word with a read strobe.

Every subaddress belongs to a region whose word is 1 to 5 bytes long. The block looks up the length from the current subaddress. It collects or serves that many bytes, and only then moves to the next subaddress. A write produces one strobe per complete word. A read fetches the whole word once, when its first byte is due, and then sends it out one byte at a time.

Top module: `i2c_wi_target`

## Requirements
- R1: After the eighth bit of a matching address byte, of either subaddress byte or of a write data byte, the block pulls SDA low for the whole ninth clock.
- R2: The word length is 4 bytes below 0x0800, 5 bytes from 0x0800 to 0x0FFF, 2 bytes from 0x1000 to 0x1FFF, 3 bytes from 0x2000 to 0x2FFF, and 1 byte from 0x3000 upwards.
- R3: The subaddress goes up by one only after a whole word has been written or read. The length of the next word is then taken from the new subaddress, including when the step crosses into a different region.
- R4: A completed write word gives exactly one single-cycle reg_wr pulse. During that pulse reg_addr holds the word's subaddress and reg_wdata holds the bytes right-justified, with the first byte received as the most significant and unused upper bytes zero. A partly written word gives no pulse.
- R5: A read is started with a repeated start and the address byte with bit 0 = 1. For each word, reg_rd pulses for one cycle when the word's first byte is due, with reg_addr set to that word's subaddress, and reg_rdata is sampled in that same cycle. The bytes then go out most significant byte first, and each byte MSB first.
- R6: If the master does not acknowledge a read byte (SDA high on the ninth clock), the block releases SDA and fetches nothing more. Until the next start it drives nothing, so further clocked bytes read as 0xFF.
- R7: An address byte whose upper seven bits do not match CHIP_ADDR is not acknowledged. The block then ignores the bus until the next start.
- R8: SDA is driven only through sda_oe (1 pulls the line low), and sda_oe changes only while SCL is low.
- R9: A start or stop at any point, including in the middle of a byte, aborts the transfer in progress and clears the bit and byte-in-word counts. The subaddress keeps its value, so a later read without a subaddress phase continues from it.
- R10: Coming out of reset, sda_oe, reg_wr and reg_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| reg_addr | output | 16 | Current subaddress towards the register space |
| reg_wdata | output | 40 | Completed write word, right-justified |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 40 | Read word, right-justified, valid in the reg_rd cycle |
| reg_rd | output | 1 | One-cycle read fetch strobe |

## Verification
The hardest case to reach from the pins is a word that is left incomplete: the bus stops or restarts, sometimes in the middle of a byte, after some but not all bytes of a multi-byte word. The only thing that shows the byte count was cleared is the absence of a strobe and the correct position of the next word. The stimulus sends two bytes of a 4-byte word plus three loose bits, issues a repeated start, and writes a 1-byte register. The bench checks that only that register is strobed, and that a following address-only read continues from the next subaddress. Region crossings mid-burst (3-byte to 1-byte, 4-byte to 5-byte) and a master NACK followed by extra clocking cover the remaining step and release paths.

// File: rtl/i2c_wi_pkg.sv
package i2c_wi_pkg;

  localparam int SUB_W     = 16;
  localparam int MAX_BYTES = 5;
  localparam int WORD_W    = 8 * MAX_BYTES;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  typedef enum logic [2:0] {
    M_IDLE, M_ADDR, M_SUBH, M_SUBL, M_WR, M_RD, M_IGNORE
  } mode_t;

  typedef enum logic [1:0] {
    P_BITS, P_WAITFALL, P_ACK, P_MACK
  } phase_t;

  // Region map: bytes per word for a subaddress.
  function automatic logic [LEN_W-1:0] word_len(input logic [SUB_W-1:0] a);
    if (a < 16'h0800)      return LEN_W'(4);
    else if (a < 16'h1000) return LEN_W'(5);
    else if (a < 16'h2000) return LEN_W'(2);
    else if (a < 16'h3000) return LEN_W'(3);
    else                   return LEN_W'(1);
  endfunction

  // Zero everything above the low len bytes.
  function automatic logic [WORD_W-1:0] mask_word(input logic [WORD_W-1:0] w,
                                                  input logic [LEN_W-1:0] len);
    logic [WORD_W-1:0] m;
    m = ~({WORD_W{1'b1}} << {len, 3'b000});
    return w & m;
  endfunction

  // Byte idx of a len-byte word, idx 0 being the most significant.
  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w,
                                           input logic [LEN_W-1:0] len,
                                           input logic [LEN_W-1:0] idx);
    logic [WORD_W-1:0] t;
    logic [LEN_W-1:0]  sel;
    sel = len - LEN_W'(1) - idx;
    t   = w >> {sel, 3'b000};
    return t[7:0];
  endfunction

endpackage

// File: rtl/i2c_wi_sync.sv
module i2c_wi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_q;
      sda_d  <= sda_q;
    end
  end

  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign scl_rise = ~scl_d & scl_q;
  assign scl_fall = scl_d & ~scl_q;
  assign start_ev = scl_d & scl_q & sda_d & ~sda_q;
  assign stop_ev  = scl_d & scl_q & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_wi_wordctl.sv
module i2c_wi_wordctl
  import i2c_wi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic [7:0]        rx_byte,
  input  logic              sub_hi_ld,
  input  logic              sub_lo_ld,
  input  logic              wr_byte,
  input  logic              rd_adv,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic [SUB_W-1:0]  subaddr,
  output logic [7:0]        tx_byte,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);
  logic [LEN_W-1:0]  byte_idx;
  logic [LEN_W-1:0]  wlen;
  logic              word_last;
  logic [WORD_W-1:0] wbuf, rbuf;

  assign wlen      = word_len(subaddr);
  assign word_last = (byte_idx + LEN_W'(1)) == wlen;
  assign reg_rd    = tx_load && (byte_idx == '0);
  assign reg_wdata = mask_word(wbuf, wlen);
  assign tx_byte   = pick_byte((byte_idx == '0) ? reg_rdata : rbuf, wlen, byte_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subaddr  <= '0;
      byte_idx <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      reg_wr   <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      if (reg_wr) subaddr <= subaddr + SUB_W'(1);
      if (abort) begin
        byte_idx <= '0;
      end else if (sub_hi_ld) begin
        subaddr[SUB_W-1:8] <= rx_byte;
      end else if (sub_lo_ld) begin
        subaddr[7:0] <= rx_byte;
        byte_idx     <= '0;
      end else if (wr_byte) begin
        wbuf <= {wbuf[WORD_W-9:0], rx_byte};
        if (word_last) begin
          reg_wr   <= 1'b1;
          byte_idx <= '0;
        end else begin
          byte_idx <= byte_idx + LEN_W'(1);
        end
      end else if (rd_adv) begin
        if (word_last) begin
          subaddr  <= subaddr + SUB_W'(1);
          byte_idx <= '0;
        end else begin
          byte_idx <= byte_idx + LEN_W'(1);
        end
      end
      if (reg_rd) rbuf <= reg_rdata;
    end
  end
endmodule

// File: rtl/i2c_wi_target.sv
module i2c_wi_target
  import i2c_wi_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR   = 7'h34,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [SUB_W-1:0]  reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_wr,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              reg_rd
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_wi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  mode_t      mode;
  phase_t     phase;
  logic [3:0] bitcnt;
  logic [7:0] rxsh, txsh;
  logic       mack_ok;

  // Named events shared by the word controller and the checker.
  logic       rx_mode, byte_done, addr_hit, bus_ignored;
  logic       sub_hi_ld, sub_lo_ld, wr_byte, rd_adv, tx_load, abort;
  logic [7:0] rx_byte_w, tx_byte;

  assign rx_mode     = (mode == M_ADDR) || (mode == M_SUBH) ||
                       (mode == M_SUBL) || (mode == M_WR);
  assign rx_byte_w   = {rxsh[6:0], sda_q};
  assign byte_done   = rx_mode && (phase == P_BITS) && scl_rise && (bitcnt == 4'd7);
  assign addr_hit    = rx_byte_w[7:1] == CHIP_ADDR;
  assign sub_hi_ld   = byte_done && (mode == M_SUBH);
  assign sub_lo_ld   = byte_done && (mode == M_SUBL);
  assign wr_byte     = byte_done && (mode == M_WR);
  assign rd_adv      = (mode == M_RD) && (phase == P_MACK) && scl_rise && !sda_q;
  assign tx_load     = (mode == M_RD) && scl_fall &&
                       ((phase == P_ACK) || ((phase == P_MACK) && mack_ok));
  assign abort       = start_ev || stop_ev;
  assign bus_ignored = (mode == M_IGNORE);

  i2c_wi_wordctl u_word (
    .clk(clk), .rst_n(rst_n), .abort(abort), .rx_byte(rx_byte_w),
    .sub_hi_ld(sub_hi_ld), .sub_lo_ld(sub_lo_ld), .wr_byte(wr_byte),
    .rd_adv(rd_adv), .tx_load(tx_load), .reg_rdata(reg_rdata),
    .subaddr(reg_addr), .tx_byte(tx_byte), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_IDLE;
      phase   <= P_BITS;
      bitcnt  <= '0;
      rxsh    <= '0;
      txsh    <= '0;
      sda_oe  <= 1'b0;
      mack_ok <= 1'b0;
    end else if (start_ev) begin
      mode   <= M_ADDR;
      phase  <= P_BITS;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      mode   <= M_IDLE;
      phase  <= P_BITS;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (phase)
        P_BITS: begin
          if (rx_mode && scl_rise) begin
            rxsh <= rx_byte_w;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              unique case (mode)
                M_ADDR: begin
                  if (addr_hit) begin
                    mode  <= rx_byte_w[0] ? M_RD : M_SUBH;
                    phase <= P_WAITFALL;
                  end else begin
                    mode <= M_IGNORE;
                  end
                end
                M_SUBH: begin
                  mode  <= M_SUBL;
                  phase <= P_WAITFALL;
                end
                M_SUBL: begin
                  mode  <= M_WR;
                  phase <= P_WAITFALL;
                end
                default: phase <= P_WAITFALL;
              endcase
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end else if (mode == M_RD) begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe  <= 1'b0;
                phase   <= P_MACK;
                mack_ok <= 1'b0;
                bitcnt  <= '0;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
        end
        P_WAITFALL: begin
          if (scl_fall) begin
            sda_oe <= 1'b1;
            phase  <= P_ACK;
          end
        end
        P_ACK: begin
          if (scl_fall) begin
            phase  <= P_BITS;
            bitcnt <= '0;
            if (mode == M_RD) begin
              txsh   <= tx_byte;
              sda_oe <= ~tx_byte[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        P_MACK: begin
          if (scl_rise) begin
            if (!sda_q) begin
              mack_ok <= 1'b1;
            end else begin
              mode  <= M_IGNORE;
              phase <= P_BITS;
            end
          end else if (scl_fall && mack_ok) begin
            txsh   <= tx_byte;
            sda_oe <= ~tx_byte[7];
            phase  <= P_BITS;
            bitcnt <= '0;
          end
        end
        default: phase <= P_BITS;
      endcase
    end
  end
endmodule

// File: rtl/i2c_wi_target_chk.sv
module i2c_wi_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_q,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_addr,
  input logic        bus_ignored
);
  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r3_step_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == $past(reg_addr) + 16'd1);

  a_r5_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !reg_wr);

  a_r8_oe_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_q));

  a_r8_oe_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !bus_ignored) |-> !$past(scl_q));

  a_r7_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ignored |-> !sda_oe);

  a_r6_no_fetch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ignored |-> !reg_rd);
endmodule

bind i2c_wi_target i2c_wi_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_q(scl_q),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .bus_ignored(bus_ignored)
);

// File: tb/i2c_wi_target_tb.sv
module i2c_wi_target_tb;
  localparam logic [6:0] CHIP = 7'h34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_line;
  logic sda_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;
  logic [39:0] reg_wdata, reg_rdata;

  int total = 0, bad = 0, wr_total = 0, rd_total = 0, oe_viol = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  logic [15:0] cw_addr [0:63];
  logic [39:0] cw_data [0:63];

  always #10 clk = ~clk;

  assign sda_line = msda & ~sda_oe;

  i2c_wi_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .reg_rd(reg_rd)
  );

  function automatic logic [39:0] pat(input logic [15:0] a);
    return {a, ~a, a[7:0] ^ 8'h3C};
  endfunction

  // R2 restated: bytes per word by region
  function automatic int blen(input logic [15:0] a);
    case (a[15:12])
      4'h0:    return a[11] ? 5 : 4;
      4'h1:    return 2;
      4'h2:    return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] pbyte(input logic [15:0] a, input int j);
    logic [39:0] p;
    p = pat(a);
    return p[8*(blen(a)-1-j) +: 8];
  endfunction

  function automatic logic [7:0] dgen(input logic [15:0] a, input int k);
    return (a[7:0] + 8'(k * 29)) ^ 8'h5A;
  endfunction

  assign reg_rdata = pat(reg_addr);

  always @(posedge clk) begin
    if (reg_wr) begin
      cw_addr[wr_total] <= reg_addr;
      cw_data[wr_total] <= reg_wdata;
      wr_total <= wr_total + 1;
    end
    if (reg_rd) rd_total <= rd_total + 1;
  end

  // R8 monitor: sda_oe may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    end
    msda = 1'b1; wq(); scl = 1'b1; wq(); ack = !sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    msda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0;
    end
    msda = give_ack ? 1'b0 : 1'b1;
    wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); msda = 1'b1;
  endtask

  // {read, byte count, start subaddress}
  localparam logic [20:0] VEC [8] = '{
    {1'b0, 4'd8,  16'h0010},
    {1'b0, 4'd10, 16'h0820},
    {1'b0, 4'd6,  16'h1004},
    {1'b0, 4'd3,  16'h4000},
    {1'b0, 4'd4,  16'h2FFF},
    {1'b1, 4'd7,  16'h0820},
    {1'b1, 4'd4,  16'h1006},
    {1'b1, 4'd5,  16'h07FF}
  };

  initial begin
    int base, nb, idx, exp_n;
    logic [15:0] a, sa;
    logic [39:0] acc;
    logic ak;
    logic [7:0] got, exb;

    repeat (5) @(posedge clk);
    #2;
    chk(sda_oe == 1'b0, "R10 sda_oe in reset", 64'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    chk(sda_oe == 1'b0, "R10 sda_oe after reset", 64'(sda_oe), 0);
    chk(reg_wr == 1'b0, "R10 reg_wr after reset", 64'(reg_wr), 0);
    chk(reg_rd == 1'b0, "R10 reg_rd after reset", 64'(reg_rd), 0);

    for (int v = 0; v < 8; v++) begin
      sa = VEC[v][15:0];
      nb = int'(VEC[v][19:16]);
      bus_start();
      send_byte({CHIP, 1'b0}, ak); chk(ak, "R1 address ack", 64'(ak), 1);
      send_byte(sa[15:8], ak);     chk(ak, "R1 subaddress high ack", 64'(ak), 1);
      send_byte(sa[7:0], ak);      chk(ak, "R1 subaddress low ack", 64'(ak), 1);
      if (!VEC[v][20]) begin
        base = wr_total;
        for (int k = 0; k < nb; k++) begin
          send_byte(dgen(sa, k), ak);
          chk(ak, "R1 data ack", 64'(ak), 1);
        end
        bus_stop(); wq();
        a = sa; idx = 0; acc = '0; exp_n = 0;
        for (int k = 0; k < nb; k++) begin
          acc = (acc << 8) | 40'(dgen(sa, k));
          idx++;
          if (idx == blen(a)) begin
            chk(cw_addr[base+exp_n] == a, "R3 write word address",
                64'(cw_addr[base+exp_n]), 64'(a));
            chk(cw_data[base+exp_n] == acc, "R4 write word data",
                64'(cw_data[base+exp_n]), 64'(acc));
            exp_n++; a++; idx = 0; acc = '0;
          end
        end
        chk(wr_total - base == exp_n, "R2 write strobe count",
            64'(wr_total - base), 64'(exp_n));
      end else begin
        base = rd_total;
        bus_start();
        send_byte({CHIP, 1'b1}, ak); chk(ak, "R5 read address ack", 64'(ak), 1);
        a = sa; idx = 0; exp_n = 0;
        for (int k = 0; k < nb; k++) begin
          if (idx == 0) exp_n++;
          recv_byte(k != nb - 1, got);
          exb = pbyte(a, idx);
          chk(got == exb, "R5 read byte", 64'(got), 64'(exb));
          idx++;
          if (idx == blen(a)) begin a++; idx = 0; end
        end
        bus_stop(); wq();
        chk(rd_total - base == exp_n, "R3 fetch count", 64'(rd_total - base), 64'(exp_n));
      end
    end

    // R7: foreign chip address
    base = wr_total;
    bus_start();
    send_byte({7'h35, 1'b0}, ak); chk(!ak, "R7 mismatch not acked", 64'(ak), 0);
    send_byte(8'h00, ak);         chk(!ak, "R7 later byte ignored", 64'(ak), 0);
    bus_stop(); wq();
    chk(wr_total == base, "R7 no strobe", 64'(wr_total - base), 0);

    // R9: partial word, loose bits, repeated start
    base = wr_total;
    bus_start();
    send_byte({CHIP, 1'b0}, ak); send_byte(8'h00, ak); send_byte(8'h10, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak);
    for (int i = 0; i < 3; i++) begin
      msda = 1'b0; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    end
    wq();
    bus_start();
    send_byte({CHIP, 1'b0}, ak); send_byte(8'h30, ak); send_byte(8'h00, ak);
    send_byte(8'hC7, ak);
    bus_stop(); wq();
    chk(wr_total - base == 1, "R9 partial word dropped", 64'(wr_total - base), 1);
    chk(cw_addr[base] == 16'h3000, "R9 strobe address", 64'(cw_addr[base]), 64'h3000);
    chk(cw_data[base] == 40'hC7, "R4 single byte data", 64'(cw_data[base]), 64'hC7);

    // R9: subaddress kept across stop
    bus_start();
    send_byte({CHIP, 1'b1}, ak);
    recv_byte(1'b0, got);
    bus_stop(); wq();
    exb = pbyte(16'h3001, 0);
    chk(got == exb, "R9 subaddress retained", 64'(got), 64'(exb));

    // R6: master NACK ends the read
    base = rd_total;
    bus_start();
    send_byte({CHIP, 1'b0}, ak); send_byte(8'h08, ak); send_byte(8'h20, ak);
    bus_start();
    send_byte({CHIP, 1'b1}, ak);
    recv_byte(1'b0, got);
    exb = pbyte(16'h0820, 0);
    chk(got == exb, "R6 byte before nack", 64'(got), 64'(exb));
    recv_byte(1'b0, got);
    chk(got == 8'hFF, "R6 line released", 64'(got), 64'hFF);
    bus_stop(); wq();
    chk(rd_total - base == 1, "R6 no further fetch", 64'(rd_total - base), 1);

    chk(oe_viol == 0, "R8 sda_oe moved with SCL high", 64'(oe_viol), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule